// File: doc/BRIEF.md
# Successive Approximation Conversion Register

This block holds the trial word and the control state for an 8-bit successive approximation analog-to-digital conversion. An external DAC turns the trial word into a voltage, and an external comparator answers one question per clock: should the bit under trial stay set? The register runs the MSB-first binary search. When the search is done it raises a done flag, and it also shows each decided bit on a serial output in the cycle that bit is settled.

Starting, continuing, holding and restarting are chosen on each rising clock edge. The choice uses the start request and the synchronous master reset as sampled at this edge, the same two inputs as sampled at the previous edge, and the done flag. A rising start request begins a conversion. So does a start request that is already high when reset is released, or one that is high while the done flag is set. Holding the request high therefore gives back-to-back conversions. Between clock edges nothing changes. The comparator input is read as 1 = keep the trial bit, which is the case when the trial value is at or below the analog input.

Top module: `sar_conv_reg`

## Requirements
- R1: When masterRst is high at a clock edge, sarWord, convDone and serialOut are all 0 after that edge, whatever startReq is, even in the middle of a conversion.
- R2: When startReq is high at an edge and was low at the previous edge, with masterRst low at both edges, a conversion starts. After that edge sarWord is 8'h80 (only bit 7 set) and convDone is 0.
- R3: When startReq is high and masterRst is low at an edge, and masterRst was high at the previous edge, a conversion starts and sarWord is 8'h80 after that edge.
- R4: On each of the 8 edges after a start, the bit under trial (bit 7 first, bit 0 last) takes the value of cmpKeep (1 = keep) and the next lower bit is set to 1. With cmpKeep = (sarWord <= input), the final word equals the input.
- R5: convDone rises on the 9th edge after the start edge, one edge after the bit 0 decision. It stays 0 before that edge.
- R6: While convDone is 1, startReq is low and masterRst is low, sarWord and convDone keep their values.
- R7: When convDone is 1 and startReq is high at an edge, a new conversion starts even if startReq was already high. After that edge convDone is 0 and sarWord is 8'h80.
- R8: A startReq rise during a conversion restarts the search. After that edge sarWord is 8'h80.
- R9: After each decision edge, serialOut equals the bit just decided, so the 8 serial values read MSB first equal the result.
- R10: During a conversion, startReq held high or dropped low (no rise) does not disturb the search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every action happens on its rising edge |
| startReq | input | 1 | Start-conversion request, sampled each edge |
| masterRst | input | 1 | Synchronous master reset, sampled each edge |
| cmpKeep | input | 1 | Comparator answer: 1 keeps the bit under trial |
| sarWord | output | 8 | Trial word during a search, result after it |
| convDone | output | 1 | End-of-conversion flag |
| serialOut | output | 1 | Value of the bit decided on the latest edge |

## Verification
The assertions check on every cycle that reset clears the word and the serial bit, that a load leaves only the MSB set, and that the word is frozen on cycles with no load and no decision. They also check that at most one control strobe is active, that the done flag rises only after the step count has run out, and that the done state holds or restarts depending on the request. Only the bench's scenarios can show that whole searches land on the right value for inputs such as 00, FF, A5 and 5A. They also show that each of the three start conditions fires on the right edge, and that the serial stream matches the result. To cover those it compares a behavioural model with the outputs every clock.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

  // Strobes sent from the control to the datapath, at most one active per edge.
  typedef struct packed {
    logic clear;   // synchronous master reset
    logic load;    // begin a new search
    logic decide;  // settle one trial bit
    logic finish;  // search complete, flag goes high
  } sarStrobes_t;

endpackage

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH + 2)
) (
  input  logic          clk,
  input  logic          startReq,
  input  logic          masterRst,
  output sarStrobes_t   strobes,
  output logic [CW-1:0] stepCnt,
  output logic          convDone
);

  logic scPrev;
  logic mrPrev;
  logic busy;
  logic startHit;
  logic stepZero;

  // Edge history of the two control inputs
  always_ff @(posedge clk) begin
    scPrev <= startReq;
    mrPrev <= masterRst;
  end

  // Three ways to begin: request rise, release from reset with request high,
  // or request high while the previous result is on show.
  assign startHit = startReq && !masterRst && (mrPrev || !scPrev || convDone);
  assign stepZero = (stepCnt == '0);

  always_comb begin
    strobes.clear  = masterRst;
    strobes.load   = startHit;
    strobes.decide = !masterRst && !startHit && busy && !stepZero;
    strobes.finish = !masterRst && !startHit && busy && stepZero;
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      busy     <= 1'b0;
      convDone <= 1'b0;
      stepCnt  <= '0;
    end else if (strobes.load) begin
      busy     <= 1'b1;
      convDone <= 1'b0;
      stepCnt  <= CW'(WIDTH);
    end else if (strobes.decide) begin
      stepCnt  <= stepCnt - 1'b1;
    end else if (strobes.finish) begin
      busy     <= 1'b0;
      convDone <= 1'b1;
    end
  end

  // R4: the strobes never overlap
  p_single_strobe_r4: assert property (@(posedge clk) disable iff (masterRst)
    $onehot0({strobes.load, strobes.decide, strobes.finish}));

  // R5: the flag rises only once the step count has reached zero in a live search
  p_done_after_count_r5: assert property (@(posedge clk) disable iff (masterRst)
    $rose(convDone) |-> ($past(busy) && $past(stepCnt) == '0));

  // R6: the result stays on show while the request is low
  p_done_retained_r6: assert property (@(posedge clk) disable iff (masterRst)
    (convDone && !startReq) |=> convDone);

  // R7: a high request with the flag set begins a new search
  p_back_to_back_r7: assert property (@(posedge clk) disable iff (masterRst)
    (convDone && startReq) |=> (!convDone && stepCnt == CW'(WIDTH)));

endmodule

// File: rtl/sar_conv_dp.sv
module sar_conv_dp
  import sar_conv_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH + 2)
) (
  input  logic             clk,
  input  sarStrobes_t      strobes,
  input  logic [CW-1:0]    stepCnt,
  input  logic             cmpKeep,
  output logic [WIDTH-1:0] sarWord,
  output logic             serialOut
);

  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] nextWord;

  // Bit b is decided while stepCnt == b+1 and becomes the trial bit while stepCnt == b+2
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      if (strobes.clear)
        nextWord[b] = 1'b0;
      else if (strobes.load)
        nextWord[b] = (b == WIDTH - 1) ? 1'b1 : 1'b0;
      else if (strobes.decide && stepCnt == CW'(b + 1))
        nextWord[b] = cmpKeep;
      else if (strobes.decide && stepCnt == CW'(b + 2))
        nextWord[b] = 1'b1;
      else
        nextWord[b] = sarWord[b];
    end
  end

  always_ff @(posedge clk) begin
    sarWord <= nextWord;
  end

  always_ff @(posedge clk) begin
    if (strobes.clear || strobes.load)
      serialOut <= 1'b0;
    else if (strobes.decide)
      serialOut <= cmpKeep;
  end

  // R1: reset empties the word and the serial bit
  p_reset_clears_r1: assert property (@(posedge clk)
    strobes.clear |=> (sarWord == '0 && !serialOut));

  // R2: a new search leaves only the MSB set
  p_load_msb_r2: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.load |=> (sarWord == MSB_ONLY));

  // R6: with no load and no decision the word is frozen
  p_idle_stable_r6: assert property (@(posedge clk) disable iff (strobes.clear)
    (!strobes.load && !strobes.decide) |=> $stable(sarWord));

  // R5: the completing edge alters no bit
  p_finish_keeps_word_r5: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.finish |=> $stable(sarWord));

  // R9: the serial output follows the comparator on a decision edge
  p_serial_follows_r9: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.decide |=> (serialOut == $past(cmpKeep)));

endmodule

// File: rtl/sar_conv_reg.sv
module sar_conv_reg
  import sar_conv_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH + 2)
) (
  input  logic             clk,
  input  logic             startReq,
  input  logic             masterRst,
  input  logic             cmpKeep,
  output logic [WIDTH-1:0] sarWord,
  output logic             convDone,
  output logic             serialOut
);

  sarStrobes_t   strobes;
  logic [CW-1:0] stepCnt;

  sar_conv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .startReq  (startReq),
    .masterRst (masterRst),
    .strobes   (strobes),
    .stepCnt   (stepCnt),
    .convDone  (convDone)
  );

  sar_conv_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .stepCnt   (stepCnt),
    .cmpKeep   (cmpKeep),
    .sarWord   (sarWord),
    .serialOut (serialOut)
  );

endmodule

// File: tb/sar_conv_reg_test.sv
module sar_conv_reg_test;

  logic       clk = 1'b0;
  logic       startReq = 1'b0;
  logic       masterRst = 1'b1;
  logic       cmpKeep;
  logic [7:0] sarWord;
  logic       convDone;
  logic       serialOut;
  logic [7:0] target = 8'h00;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  // Comparator model: keep the trial bit when the trial value does not exceed the input
  assign cmpKeep = (sarWord <= target);

  sar_conv_reg uut (
    .clk       (clk),
    .startReq  (startReq),
    .masterRst (masterRst),
    .cmpKeep   (cmpKeep),
    .sarWord   (sarWord),
    .convDone  (convDone),
    .serialOut (serialOut)
  );

  // Behavioural reference: bit position counts down, -1 = flag pending, -2 = idle
  logic [7:0] mWord;
  bit   mDone, mSer, pSc, pMr, mValid;
  int   mPos = -2;

  always @(posedge clk) begin
    bit sc, mr, keep;
    sc = startReq;
    mr = masterRst;
    if (mr) begin
      mWord = 8'h00; mDone = 0; mSer = 0; mPos = -2; mValid = 1;
    end else if (sc && (pMr || !pSc || mDone)) begin
      mWord = 8'h80; mDone = 0; mSer = 0; mPos = 7;
    end else if (mPos >= 0) begin
      keep = (mWord <= target);
      mWord[mPos] = keep;
      mSer = keep;
      if (mPos > 0) mWord[mPos-1] = 1'b1;
      mPos = mPos - 1;
    end else if (mPos == -1) begin
      mDone = 1; mPos = -2;
    end
    pSc = sc;
    pMr = mr;
  end

  always @(negedge clk) begin
    if (mValid) begin
      checks++;
      if (sarWord !== mWord || convDone !== mDone || serialOut !== mSer) begin
        errors++;
        $display("FAIL model R4 R5 R9: word=%h done=%b ser=%b expected word=%h done=%b ser=%b",
                 sarWord, convDone, serialOut, mWord, mDone, mSer);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic convert(logic [7:0] value);
    logic [7:0] serVal;
    serVal = '0;
    target = value;
    startReq = 1'b1;
    cyc();
    check("R2 word after start", sarWord, 8'h80);
    check("R2 done after start", convDone, 0);
    startReq = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cyc();
      serVal = {serVal[6:0], serialOut};
    end
    check("R5 done low after bit 0", convDone, 0);
    check("R9 serial stream", serVal, value);
    cyc();
    check("R5 done high", convDone, 1);
    check("R4 result", sarWord, value);
  endtask

  initial begin
    repeat (2) cyc();
    check("R1 reset word", sarWord, 0);
    check("R1 reset done", convDone, 0);
    check("R1 reset serial", serialOut, 0);
    masterRst = 1'b0;
    cyc();

    convert(8'hA5);
    convert(8'h00);
    convert(8'hFF);
    convert(8'h5A);

    // R6: result held while the request is low
    repeat (3) cyc();
    check("R6 word held", sarWord, 8'h5A);
    check("R6 done held", convDone, 1);

    // R7 and R10: request held high across a whole search, then back-to-back
    target = 8'h33;
    startReq = 1'b1;
    cyc();
    repeat (9) cyc();
    check("R10 held request result", sarWord, 8'h33);
    check("R10 held request done", convDone, 1);
    cyc();
    check("R7 back-to-back word", sarWord, 8'h80);
    check("R7 back-to-back done", convDone, 0);
    startReq = 1'b0;
    repeat (9) cyc();
    check("R10 dropped request result", sarWord, 8'h33);
    check("R10 dropped request done", convDone, 1);

    // R8: restart part way through
    target = 8'hC3;
    startReq = 1'b1;
    cyc();
    startReq = 1'b0;
    repeat (3) cyc();
    target = 8'h6E;
    startReq = 1'b1;
    cyc();
    check("R8 restart word", sarWord, 8'h80);
    check("R8 restart done", convDone, 0);
    startReq = 1'b0;
    repeat (9) cyc();
    check("R8 restart result", sarWord, 8'h6E);

    // R1: reset during a search with the request high
    target = 8'h9C;
    startReq = 1'b1;
    cyc();
    repeat (2) cyc();
    masterRst = 1'b1;
    cyc();
    check("R1 mid reset word", sarWord, 0);
    check("R1 mid reset serial", serialOut, 0);
    cyc();
    check("R1 reset with request done", convDone, 0);

    // R3: release reset with the request already high
    masterRst = 1'b0;
    cyc();
    check("R3 release start word", sarWord, 8'h80);
    startReq = 1'b0;
    repeat (9) cyc();
    check("R3 release result", sarWord, 8'h9C);
    check("R3 release done", convDone, 1);

    cyc();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule